// File: doc/BRIEF.md
# Four-Queue Cell Multiplexer with Round-Robin Arbitration

This block combines four byte-wide cell queues into one 16-bit output stream and moves exactly one whole cell (53 bytes) per grant. On the write side, a per-queue framer decides which incoming bytes belong to a cell. It tags the opening byte of each cell with a boundary marker, so every queue entry is 9 bits wide. It also counts the complete cells that each queue holds. The queue storage itself sits outside the block. The block drives the write strobes and the tagged entries into that storage. It reads back the head entry of each queue, which the storage presents first-word-fall-through, and pops it with a per-queue read strobe.

Two arbitration styles exist. With the sequencer enabled, the block searches round-robin for the next queue that holds a complete cell and shows the chosen queue number on a 2-bit select output. When the block is also the master, it pulses a load output one cycle before the cell starts, so that a slave device can latch the select. With the sequencer disabled, an external agent places a queue number on the select input and pulses the load input, and that choice governs the next cell. On the output side, bytes are packed in pairs into 16-bit words with a selectable lane order. A start-of-cell flag marks the word that carries each cell's first byte.

Top module: `rcm_top`

## Requirements
- R1: While reset is held, outValid, outSoc, loadOut and every qRdEn bit are 0, and selOut is 0.
- R2: A framer writes a byte (qWrEn high) only if it is inside a cell or its start flag is high. A byte that arrives with the start flag outside a cell opens a cell and is stored with entry bit 8 = 1. The start flag is ignored on the other 52 bytes of that cell, which are stored with bit 8 = 0. A byte that arrives outside a cell without the start flag is not written.
- R3: A transfer pops exactly 53 consecutive entries. The pops come from a single queue, with one qRdEn bit high per cycle, and the source never changes inside a cell.
- R4: With rrEnable = 1, the search begins at the queue after the one served last, wraps from 3 to 0, and skips queues that hold no complete cell. After reset, queue 0 is searched first.
- R5: A queue that holds only part of a cell is never served. When no eligible cell exists, all qRdEn bits stay 0.
- R6: With rrEnable = 1 and masterMode = 1, loadOut pulses for one cycle while selOut shows the granted queue, and that queue's first pop happens in the next cycle. selOutEn equals rrEnable.
- R7: With rrEnable = 1 and masterMode = 0, the sequencer still selects queues, but loadOut stays 0.
- R8: With rrEnable = 0, a loadIn pulse latches selIn as the queue for the next cell. A loadIn pulse during a transfer does not alter the cell in progress; its queue is served afterwards. Without a latched select, nothing is served.
- R9: Output words pair bytes (0,1), (2,3) and so on, giving 27 words per cell. The last word holds byte 52 and a zero pad byte. With swapBytes = 0, the earlier byte sits in outData[7:0]. With swapBytes = 1, it sits in outData[15:8].
- R10: outSoc is high on the first word of each cell and on no other word. It is only ever high together with outValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rstN | input | 1 | Active-low synchronous reset |
| rrEnable | input | 1 | 1: sequencer picks queues; 0: external select |
| masterMode | input | 1 | 1: announce each grant on loadOut |
| swapBytes | input | 1 | 1: earlier byte in the upper lane |
| selIn | input | 2 | Externally supplied queue number |
| loadIn | input | 1 | Latches selIn for the next cell |
| selOut | output | 2 | Granted queue number in sequencer mode |
| selOutEn | output | 1 | selOut is being driven |
| loadOut | output | 1 | One-cycle announce pulse for a slave |
| wrValid | input | 4 | Per-queue incoming byte valid |
| wrData | input | 32 | Per-queue incoming bytes, queue i in bits 8i+7:8i |
| wrSoc | input | 4 | Per-queue start-of-cell flag |
| qWrEn | output | 4 | Per-queue storage write strobe |
| qWrEntry | output | 36 | Per-queue 9-bit entry, bit 8 = cell start marker |
| qRdEn | output | 4 | Per-queue pop strobe |
| qRdEntry | input | 36 | Per-queue head entry from storage |
| outValid | output | 1 | outData holds a word |
| outData | output | 16 | Packed output word |
| outSoc | output | 1 | Word carries a cell's first byte |

## Verification
The hardest situations to reach are those where the search has to wrap past empty queues while another queue holds only part of a cell. Other hard cases are a new external select that arrives while a cell is still streaming. To reach them, cells are loaded while the sequencer is disabled and no select is latched, so nothing drains. The sequencer is then switched on and the order of service is read off the pop strobes. For the mid-cell case, the second loadIn pulse is timed a few cycles after the first pop, and the bench confirms that the running cell keeps its source and the new queue follows it.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  localparam int ENTRY_W = 9;

  typedef struct packed {
    logic startCell;
    logic popByte;
    logic lastByte;
  } rcm_strobe_t;
endpackage

// File: rtl/rcm_framer.sv
module rcm_framer #(
  parameter int CELL_BYTES = 53
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic [7:0] wrByte,
  input  logic       wrSoc,
  output logic       wrEn,
  output logic [8:0] entry,
  output logic       cellDone
);
  localparam int CNT_W = $clog2(CELL_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_BYTES - 1);

  logic             inCell;
  logic [CNT_W-1:0] byteCnt;

  always_comb begin
    wrEn     = wrValid && (inCell || wrSoc);
    entry    = {!inCell, wrByte};
    cellDone = wrValid && inCell && (byteCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inCell  <= 1'b0;
      byteCnt <= '0;
    end else if (wrValid) begin
      if (!inCell) begin
        if (wrSoc) begin
          inCell  <= 1'b1;
          byteCnt <= CNT_W'(1);
        end
      end else if (byteCnt == LAST) begin
        inCell  <= 1'b0;
        byteCnt <= '0;
      end else begin
        byteCnt <= byteCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rcm_ctrl.sv
module rcm_ctrl
  import rcm_pkg::*;
#(
  parameter int NUM_Q      = 4,
  parameter int CELL_BYTES = 53,
  parameter int CELLCNT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rrEnable,
  input  logic                     masterMode,
  input  logic [$clog2(NUM_Q)-1:0] selIn,
  input  logic                     loadIn,
  input  logic [NUM_Q-1:0]         cellDone,
  output rcm_strobe_t              strobe,
  output logic [$clog2(NUM_Q)-1:0] srcSel,
  output logic [$clog2(NUM_Q)-1:0] selOut,
  output logic                     selOutEn,
  output logic                     loadOut,
  output logic [NUM_Q-1:0]         qRdEn
);
  localparam int SEL_W = $clog2(NUM_Q);
  localparam int CNT_W = $clog2(CELL_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_BYTES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ANNOUNCE, ST_XFER} state_t;

  state_t               state;
  logic [SEL_W-1:0]     grant;
  logic [SEL_W-1:0]     lastServed;
  logic [SEL_W-1:0]     pendSel;
  logic                 pendValid;
  logic [CNT_W-1:0]     byteCnt;
  logic [CELLCNT_W-1:0] cellCnt [NUM_Q];
  logic [NUM_Q-1:0]     hasCell;

  logic                 rrFound;
  logic [SEL_W-1:0]     rrPick;
  logic                 candFound;
  logic [SEL_W-1:0]     cand;

  always_comb begin
    for (int i = 0; i < NUM_Q; i++) hasCell[i] = (cellCnt[i] != '0);
  end

  // nearest eligible queue after lastServed: scan far to near, nearest wins
  always_comb begin
    int idx;
    rrFound = 1'b0;
    rrPick  = lastServed;
    for (int off = NUM_Q; off >= 1; off--) begin
      idx = (int'(lastServed) + off) % NUM_Q;
      if (hasCell[idx]) begin
        rrFound = 1'b1;
        rrPick  = SEL_W'(idx);
      end
    end
  end

  always_comb begin
    if (rrEnable) begin
      candFound = rrFound;
      cand      = rrPick;
    end else begin
      candFound = pendValid && hasCell[pendSel];
      cand      = pendSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      grant      <= '0;
      lastServed <= SEL_W'(NUM_Q - 1);
      byteCnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (candFound) begin
          grant <= cand;
          state <= ST_ANNOUNCE;
        end
        ST_ANNOUNCE: begin
          byteCnt <= '0;
          state   <= ST_XFER;
        end
        ST_XFER: begin
          if (byteCnt == LAST) begin
            lastServed <= grant;
            state      <= ST_IDLE;
          end else begin
            byteCnt <= byteCnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // external select: consumed on grant, a fresh load wins over the clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendSel   <= '0;
    end else begin
      if (state == ST_IDLE && candFound && !rrEnable) pendValid <= 1'b0;
      if (loadIn && !rrEnable) begin
        pendValid <= 1'b1;
        pendSel   <= selIn;
      end
    end
  end

  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : g_cnt
      logic take;
      assign take = (state == ST_ANNOUNCE) && (grant == SEL_W'(q));
      always_ff @(posedge clk) begin
        if (!rstN) cellCnt[q] <= '0;
        else cellCnt[q] <= cellCnt[q] + CELLCNT_W'(cellDone[q]) - CELLCNT_W'(take);
      end
      assign qRdEn[q] = (state == ST_XFER) && (grant == SEL_W'(q));
    end
  endgenerate

  always_comb begin
    strobe.startCell = (state == ST_ANNOUNCE);
    strobe.popByte   = (state == ST_XFER);
    strobe.lastByte  = (state == ST_XFER) && (byteCnt == LAST);
    srcSel           = grant;
    selOut           = rrEnable ? grant : '0;
    selOutEn         = rrEnable;
    loadOut          = (state == ST_ANNOUNCE) && rrEnable && masterMode;
  end
endmodule

// File: rtl/rcm_datapath.sv
module rcm_datapath
  import rcm_pkg::*;
#(
  parameter int NUM_Q = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rcm_strobe_t                strobe,
  input  logic [$clog2(NUM_Q)-1:0]   srcSel,
  input  logic                       swapBytes,
  input  logic [NUM_Q*ENTRY_W-1:0]   qRdEntry,
  output logic                       outValid,
  output logic [15:0]                outData,
  output logic                       outSoc
);
  logic [ENTRY_W-1:0] cur;
  logic [7:0]         holdByte;
  logic               holdMark;
  logic               haveHold;

  assign cur = qRdEntry[int'(srcSel)*ENTRY_W +: ENTRY_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte <= '0;
      holdMark <= 1'b0;
      haveHold <= 1'b0;
      outValid <= 1'b0;
      outData  <= '0;
      outSoc   <= 1'b0;
    end else begin
      outValid <= 1'b0;
      outSoc   <= 1'b0;
      if (strobe.startCell) begin
        haveHold <= 1'b0;
      end else if (strobe.popByte) begin
        if (haveHold) begin
          outValid <= 1'b1;
          outSoc   <= holdMark;
          outData  <= swapBytes ? {holdByte, cur[7:0]} : {cur[7:0], holdByte};
          haveHold <= 1'b0;
        end else if (strobe.lastByte) begin
          outValid <= 1'b1;
          outSoc   <= cur[8];
          outData  <= swapBytes ? {cur[7:0], 8'h00} : {8'h00, cur[7:0]};
        end else begin
          holdByte <= cur[7:0];
          holdMark <= cur[8];
          haveHold <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rcm_top.sv
module rcm_top
  import rcm_pkg::*;
#(
  parameter int NUM_Q      = 4,
  parameter int CELL_BYTES = 53,
  parameter int CELLCNT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rrEnable,
  input  logic                       masterMode,
  input  logic                       swapBytes,
  input  logic [$clog2(NUM_Q)-1:0]   selIn,
  input  logic                       loadIn,
  output logic [$clog2(NUM_Q)-1:0]   selOut,
  output logic                       selOutEn,
  output logic                       loadOut,
  input  logic [NUM_Q-1:0]           wrValid,
  input  logic [NUM_Q*8-1:0]         wrData,
  input  logic [NUM_Q-1:0]           wrSoc,
  output logic [NUM_Q-1:0]           qWrEn,
  output logic [NUM_Q*ENTRY_W-1:0]   qWrEntry,
  output logic [NUM_Q-1:0]           qRdEn,
  input  logic [NUM_Q*ENTRY_W-1:0]   qRdEntry,
  output logic                       outValid,
  output logic [15:0]                outData,
  output logic                       outSoc
);
  localparam int SEL_W = $clog2(NUM_Q);

  logic [NUM_Q-1:0] cellDone;
  rcm_strobe_t      strobe;
  logic [SEL_W-1:0] srcSel;

  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : g_frm
      rcm_framer #(.CELL_BYTES(CELL_BYTES)) u_frm (
        .clk     (clk),
        .rstN    (rstN),
        .wrValid (wrValid[q]),
        .wrByte  (wrData[q*8 +: 8]),
        .wrSoc   (wrSoc[q]),
        .wrEn    (qWrEn[q]),
        .entry   (qWrEntry[q*ENTRY_W +: ENTRY_W]),
        .cellDone(cellDone[q])
      );
    end
  endgenerate

  rcm_ctrl #(.NUM_Q(NUM_Q), .CELL_BYTES(CELL_BYTES), .CELLCNT_W(CELLCNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rrEnable  (rrEnable),
    .masterMode(masterMode),
    .selIn     (selIn),
    .loadIn    (loadIn),
    .cellDone  (cellDone),
    .strobe    (strobe),
    .srcSel    (srcSel),
    .selOut    (selOut),
    .selOutEn  (selOutEn),
    .loadOut   (loadOut),
    .qRdEn     (qRdEn)
  );

  rcm_datapath #(.NUM_Q(NUM_Q)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .srcSel   (srcSel),
    .swapBytes(swapBytes),
    .qRdEntry (qRdEntry),
    .outValid (outValid),
    .outData  (outData),
    .outSoc   (outSoc)
  );
endmodule

// File: rtl/rcm_chk.sv
module rcm_chk #(
  parameter int NUM_Q      = 4,
  parameter int CELL_BYTES = 53
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     loadOut,
  input logic [$clog2(NUM_Q)-1:0] selOut,
  input logic [NUM_Q-1:0]         qRdEn,
  input logic                     outValid,
  input logic                     outSoc
);
  localparam int RUN_W = $clog2(CELL_BYTES + 1);

  logic [RUN_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) runCnt <= '0;
    else if (|qRdEn) runCnt <= runCnt + RUN_W'(1);
    else runCnt <= '0;
  end

  // R3
  pop_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(qRdEn));

  // R3
  pop_src_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|qRdEn) && (|$past(qRdEn))) |-> (qRdEn == $past(qRdEn)));

  // R3
  run_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(|qRdEn) && runCnt != '0) |-> (runCnt == RUN_W'(CELL_BYTES)));

  // R6
  announce_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadOut |=> (qRdEn == (NUM_Q'(1) << $past(selOut))));

  // R10
  soc_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSoc |-> outValid);
endmodule

bind rcm_top rcm_chk #(.NUM_Q(NUM_Q), .CELL_BYTES(CELL_BYTES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .loadOut (loadOut),
  .selOut  (selOut),
  .qRdEn   (qRdEn),
  .outValid(outValid),
  .outSoc  (outSoc)
);

// File: tb/tb_rcm_top.sv
module tb_rcm_top;
  localparam int CLK_PERIOD = 10;
  localparam int CELL = 53;
  localparam int WPC = 27;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rrEnable, masterMode, swapBytes, loadIn;
  logic [1:0]  selIn, selOut;
  logic        selOutEn, loadOut;
  logic [3:0]  wrValid, wrSoc, qWrEn, qRdEn;
  logic [31:0] wrData;
  logic [35:0] qWrEntry, qRdEntry;
  logic        outValid, outSoc;
  logic [15:0] outData;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcm_top dut (
    .clk(clk), .rstN(rstN), .rrEnable(rrEnable), .masterMode(masterMode),
    .swapBytes(swapBytes), .selIn(selIn), .loadIn(loadIn), .selOut(selOut),
    .selOutEn(selOutEn), .loadOut(loadOut), .wrValid(wrValid), .wrData(wrData),
    .wrSoc(wrSoc), .qWrEn(qWrEn), .qWrEntry(qWrEntry), .qRdEn(qRdEn),
    .qRdEntry(qRdEntry), .outValid(outValid), .outData(outData), .outSoc(outSoc)
  );

  // storage model, first-word-fall-through
  logic [8:0] mem [4][128];
  logic [6:0] wp [4];
  logic [6:0] rp [4];

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (!rstN) begin
        wp[i] <= '0;
        rp[i] <= '0;
      end else begin
        if (qWrEn[i]) begin
          mem[i][wp[i]] <= qWrEntry[i*9 +: 9];
          wp[i] <= wp[i] + 7'd1;
        end
        if (qRdEn[i]) rp[i] <= rp[i] + 7'd1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++) qRdEntry[i*9 +: 9] = mem[i][rp[i]];
  end

  // observation of the ports
  int served [64];
  int nServed = 0;
  logic [15:0] words [2048];
  logic        socs [2048];
  int nWords = 0;
  int nLoad = 0;
  int loadBad = 0;
  int runBad = 0;
  int curRun = 0;
  logic [3:0] runSrc = '0;
  int expectSel = -1;

  always @(negedge clk) begin
    if (rstN) begin
      if (expectSel >= 0) begin
        if (qRdEn != (4'd1 << expectSel)) loadBad++;
        expectSel = -1;
      end
      if (loadOut) begin
        nLoad++;
        expectSel = int'(selOut);
      end
      if (|qRdEn) begin
        if (curRun == 0) begin
          runSrc = qRdEn;
          for (int i = 0; i < 4; i++) if (qRdEn[i]) served[nServed] = i;
          nServed++;
        end else if (qRdEn != runSrc) runBad++;
        curRun++;
      end else if (curRun != 0) begin
        if (curRun != CELL) runBad++;
        curRun = 0;
      end
      if (outValid) begin
        words[nWords] = outData;
        socs[nWords] = outSoc;
        nWords++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bytes k0..k0+n-1 of a cell on queue q; start flag on byte 0 and on extraSoc
  task automatic writeBytes(input int q, input logic [7:0] seed, input int k0,
                            input int n, input int extraSoc);
    for (int k = k0; k < k0 + n; k++) begin
      @(negedge clk);
      wrValid = 4'd1 << q;
      wrData = '0;
      wrData[q*8 +: 8] = seed + 8'(k);
      wrSoc = ((k == 0) || (k == extraSoc)) ? (4'd1 << q) : 4'd0;
      #1;
      if (k == 0 || k == extraSoc)
        check(qWrEn[q] && (qWrEntry[q*9 + 8] == (k == 0)), "R2",
              "start marker", int'(qWrEntry[q*9 + 8]), (k == 0) ? 1 : 0);
    end
    @(negedge clk);
    wrValid = '0;
    wrSoc = '0;
    wrData = '0;
  endtask

  task automatic checkCell(input int j, input logic [7:0] seed, input bit swp);
    int errs = 0;
    int firstBad = -1;
    logic [15:0] expWord = '0;
    for (int k = 0; k < WPC; k++) begin
      logic [7:0] a;
      logic [7:0] b;
      logic [15:0] e;
      a = seed + 8'(2*k);
      b = (2*k + 1 < CELL) ? seed + 8'(2*k + 1) : 8'h00;
      e = swp ? {a, b} : {b, a};
      if (words[j*WPC + k] !== e && firstBad < 0) begin
        firstBad = k;
        expWord = e;
      end
      if (words[j*WPC + k] !== e) errs++;
      if (socs[j*WPC + k] !== (k == 0)) errs++;
    end
    if (firstBad >= 0)
      check(1'b0, "R9", $sformatf("cell %0d word %0d", j, firstBad),
            int'(words[j*WPC + firstBad]), int'(expWord));
    else check(1'b1, "R9", "cell words", 0, 0);
    check(socs[j*WPC] === 1'b1 && errs == 0, "R10", $sformatf("cell %0d start flag", j),
          errs, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    rrEnable = 1'b0; masterMode = 1'b1; swapBytes = 1'b0;
    selIn = '0; loadIn = 1'b0;
    wrValid = '0; wrSoc = '0; wrData = '0;
    idleCycles(3);
    check(!outValid && !outSoc && !loadOut && qRdEn == 4'd0 && selOut == 2'd0,
          "R1", "reset outputs", {outValid, outSoc, loadOut, qRdEn, selOut}, 0);
    rstN = 1'b1;
    idleCycles(2);
  endtask

  task automatic testFramer();
    @(negedge clk);
    wrValid = 4'b0001; wrData = 32'h0000_00EE; wrSoc = '0;
    #1;
    check(qWrEn == 4'd0, "R2", "stray byte written", int'(qWrEn), 0);
    // cell on q0 with a stray start flag at byte 10
    writeBytes(0, 8'h10, 0, CELL, 10);
    idleCycles(5);
    check(qRdEn == 4'd0 && nServed == 0, "R8", "no select latched", nServed, 0);
  endtask

  task automatic testRoundRobin();
    writeBytes(2, 8'h40, 0, CELL, 30);
    writeBytes(1, 8'h70, 0, 20, -1);
    idleCycles(3);
    check(nServed == 0, "R5", "served while disabled", nServed, 0);
    rrEnable = 1'b1;
    #1;
    check(selOutEn == 1'b1, "R6", "select driven", int'(selOutEn), 1);
    idleCycles(200);
    check(nServed == 2 && served[0] == 0 && served[1] == 2, "R4", "order 0 then 2",
          served[1], 2);
    check(qRdEn == 4'd0, "R5", "partial cell held back", int'(qRdEn), 0);
    check(nLoad == 2 && loadBad == 0, "R6", "announce pulses", nLoad, 2);
    check(runBad == 0, "R3", "whole cell runs", runBad, 0);
    checkCell(0, 8'h10, 1'b0);
    checkCell(1, 8'h40, 1'b0);
  endtask

  task automatic testWrap();
    rrEnable = 1'b0;
    writeBytes(1, 8'h70, 20, CELL - 20, 25);
    writeBytes(0, 8'h90, 0, CELL, -1);
    idleCycles(2);
    check(nServed == 2, "R8", "held while disabled", nServed, 2);
    rrEnable = 1'b1;
    idleCycles(200);
    check(nServed == 4 && served[2] == 0 && served[3] == 1, "R4", "wrap order 0 then 1",
          served[3], 1);
    check(runBad == 0, "R3", "whole cell runs", runBad, 0);
    checkCell(2, 8'h90, 1'b0);
    checkCell(3, 8'h70, 1'b0);
  endtask

  task automatic testSlave();
    int loadsBefore = nLoad;
    masterMode = 1'b0;
    swapBytes = 1'b1;
    writeBytes(3, 8'hC0, 0, CELL, -1);
    idleCycles(120);
    check(nServed == 5 && served[4] == 3, "R7", "slave still serves", served[4], 3);
    check(nLoad == loadsBefore, "R7", "no announce as slave", nLoad, loadsBefore);
    checkCell(4, 8'hC0, 1'b1);
  endtask

  task automatic testUserSelect();
    int loadsBefore = nLoad;
    rrEnable = 1'b0;
    masterMode = 1'b1;
    swapBytes = 1'b0;
    #1;
    check(selOutEn == 1'b0, "R6", "select released", int'(selOutEn), 0);
    writeBytes(1, 8'h20, 0, CELL, -1);
    writeBytes(2, 8'h50, 0, CELL, -1);
    idleCycles(3);
    check(nServed == 5, "R8", "idle without load", nServed, 5);
    @(negedge clk);
    selIn = 2'd2; loadIn = 1'b1;
    @(negedge clk);
    loadIn = 1'b0;
    idleCycles(8);
    check(qRdEn == 4'b0100, "R8", "loaded queue popping", int'(qRdEn), 4);
    selIn = 2'd1; loadIn = 1'b1;
    @(negedge clk);
    loadIn = 1'b0;
    idleCycles(10);
    check(qRdEn == 4'b0100, "R8", "mid-cell load ignored", int'(qRdEn), 4);
    idleCycles(150);
    check(nServed == 7 && served[5] == 2 && served[6] == 1, "R8", "order 2 then 1",
          served[6], 1);
    check(runBad == 0, "R3", "whole cell runs", runBad, 0);
    check(nLoad == loadsBefore, "R6", "no announce in user mode", nLoad, loadsBefore);
    checkCell(5, 8'h50, 1'b0);
    checkCell(6, 8'h20, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testFramer();
    testRoundRobin();
    testWrap();
    testSlave();
    testUserSelect();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule